// File: doc/BRIEF.md
# Incrementing I/O-Space Pattern Writer

This block executes a single I/O-space fill command. Once a start pulse arrives, it issues a run of 32-bit bus writes over a valid/ready write port. Each write goes to an address that advances by a programmable step. The data either advances by its own programmable step or, in copy mode, is taken word by word from an input stream. Decoding the command is the job of the logic upstream. That logic presents the command fields on the input ports and pulses `start`.

In pattern mode the seed data can be adjusted once before the first write. The system-memory base is rotated left and a low-order field of it replaces the same bits of the seed. An enable bit and two small fields of a control word decide whether this happens and how. When the last write has been accepted, `done` rises for one cycle.

Top module: `io_pattern_writer`

## Requirements
- R1: Seed adjustment happens only when bit 31 of `ins_ctl` is 1. With bit 31 at 0 the first write carries `seed_data` unchanged, even when the length and rotation fields hold nonzero values.
- R2: When the adjustment is enabled, `mem_base` is rotated left by `ins_ctl[4:0]` positions. The low `ins_ctl[9:5]` bits of the rotated value then replace the same low bits of the seed. This happens once, before the first write. The later data steps start from the adjusted seed.
- R3: In pattern mode, write k (counting from 0) goes to `start_addr + k*addr_step` and carries `seed' + k*data_step`.
- R4: Exactly `word_count` writes are issued. `done` is high for exactly one cycle, in the cycle after the last write is accepted. `busy` is low from that cycle on, and `wr_valid` is never high while `busy` is low.
- R5: Address and data arithmetic wraps modulo 2^32. A negative step can be given in two's complement.
- R6: An enabled adjustment with a length field of 0 leaves the seed unchanged.
- R7: In copy mode (`copy_mode`=1 at start), write k carries stream word k in arrival order and ignores `data_step`. The address still advances by `addr_step`. A stream word is consumed (`in_ready`) only in the cycle its write is accepted.
- R8: A `word_count` of 0 raises `done` in the cycle after start and produces no write.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values into the next cycle.
- R10: A start pulse that arrives while `busy` is high is ignored. The command in progress continues unchanged.
- R11: During and right after reset, `wr_valid`, `in_ready`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches a command while idle |
| copy_mode | input | 1 | 1: data taken from the input stream |
| start_addr | input | 32 | Address of the first write |
| word_count | input | 16 | Number of writes |
| seed_data | input | 32 | Initial data value |
| ins_ctl | input | 32 | Bit 31 enable, bits 9:5 length, bits 4:0 rotation |
| data_step | input | 32 | Added to data after each write |
| addr_step | input | 32 | Added to address after each write |
| mem_base | input | 32 | System-memory base used for the seed adjustment |
| in_data | input | 32 | Stream data word (copy mode) |
| in_valid | input | 1 | Stream word available |
| in_ready | output | 1 | Stream word consumed this cycle |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses several pattern commands, and each one separates one part of the behaviour. A plain ascending fill shows the basic stepping. An enabled rotate-and-insert with a nonzero rotation shows the direction and the field width. A length field of 0, and an enable bit of 0 with nonzero fields, show the two ways the seed stays untouched. Other commands cover a fill that crosses the top of the address space, a descending address step, and a copy run that must follow the stream order while ignoring the data step. A ready line that stalls every third cycle exposes any output that moves during a stall. Separate directed tests apply a start pulse in the middle of a run and a zero-length command, to show whether a second command leaks in and whether a spurious write appears.

// File: rtl/pwr_pkg.sv
// Shared types and field positions for the pattern writer.
// Assumes a power-of-two data width so the rotation field covers it.
package pwr_pkg;
    typedef enum logic {
        PWR_IDLE = 1'b0,
        PWR_RUN  = 1'b1
    } pwr_state_e;

    // Width of the rotation and length fields for a given data width.
    function automatic int unsigned fld_w(input int unsigned dw);
        return $clog2(dw);
    endfunction
endpackage

// File: rtl/pwr_seed_merge.sv
// Combinational seed adjustment: rotates the memory base left by the rotation
// field and deposits the low 'length' bits into the seed when enabled.
// Assumes: the control word's top bit is the enable; length 0 means no change.
module pwr_seed_merge #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] seed_in,
    input  logic [DW-1:0] base_in,
    input  logic [DW-1:0] ctl_in,
    output logic [DW-1:0] seed_out
);
    localparam int unsigned FW = pwr_pkg::fld_w(DW);

    logic [FW-1:0] rot_amt;
    logic [FW-1:0] fld_len;
    logic          ins_en;
    logic [DW-1:0] rotated;
    logic [DW-1:0] fld_mask;

    assign rot_amt = ctl_in[FW-1:0];
    assign fld_len = ctl_in[2*FW-1:FW];
    assign ins_en  = ctl_in[DW-1];

    // Rotate left, build the field mask and merge.
    always_comb begin
        rotated  = (base_in << rot_amt) | (base_in >> (DW - 32'(rot_amt)));
        fld_mask = (DW'(1) << fld_len) - DW'(1);
        if (ins_en && (fld_len != '0))
            seed_out = (seed_in & ~fld_mask) | (rotated & fld_mask);
        else
            seed_out = seed_in;
    end
endmodule

// File: rtl/pwr_sequencer.sv
// Write sequencer: loads a command on start, issues count writes over a
// valid/ready port, steps address (and data in pattern mode), pulses done.
// Assumes: the stream source holds its word while in_ready is low.
module pwr_sequencer #(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          copy_mode,
    input  logic [DW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic [DW-1:0] seed_eff,
    input  logic [DW-1:0] data_step,
    input  logic [DW-1:0] addr_step,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          wr_valid,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready,
    output logic          busy,
    output logic          done
);
    import pwr_pkg::*;

    pwr_state_e    state_q;
    logic [DW-1:0] addr_q, data_q, dstep_q, astep_q;
    logic [CW-1:0] left_q;
    logic          copy_q;
    logic          fire;

    assign busy     = (state_q == PWR_RUN);
    assign wr_valid = busy && (copy_q ? in_valid : 1'b1);
    assign wr_addr  = addr_q;
    assign wr_data  = copy_q ? in_data : data_q;
    assign in_ready = busy && copy_q && wr_ready;
    assign fire     = wr_valid && wr_ready;

    // Command load, per-write stepping and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            dstep_q <= '0;
            astep_q <= '0;
            left_q  <= '0;
            copy_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                PWR_IDLE: begin
                    if (start) begin
                        if (word_count == '0) begin
                            done <= 1'b1;
                        end else begin
                            state_q <= PWR_RUN;
                            addr_q  <= start_addr;
                            data_q  <= seed_eff;
                            dstep_q <= data_step;
                            astep_q <= addr_step;
                            left_q  <= word_count;
                            copy_q  <= copy_mode;
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        addr_q <= addr_q + astep_q;
                        if (!copy_q)
                            data_q <= data_q + dstep_q;
                        left_q <= left_q - CW'(1);
                        if (left_q == CW'(1)) begin
                            state_q <= PWR_IDLE;
                            done    <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/io_pattern_writer.sv
// Top of the I/O-space pattern writer: seed adjustment feeding the write
// sequencer. Assumes command inputs are valid in the cycle start is high.
module io_pattern_writer #(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          copy_mode,
    input  logic [DW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic [DW-1:0] seed_data,
    input  logic [DW-1:0] ins_ctl,
    input  logic [DW-1:0] data_step,
    input  logic [DW-1:0] addr_step,
    input  logic [DW-1:0] mem_base,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          wr_valid,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready,
    output logic          busy,
    output logic          done
);
    logic [DW-1:0] seed_eff;

    pwr_seed_merge #(.DW(DW)) u_merge (
        .seed_in  (seed_data),
        .base_in  (mem_base),
        .ctl_in   (ins_ctl),
        .seed_out (seed_eff)
    );

    pwr_sequencer #(.DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .copy_mode  (copy_mode),
        .start_addr (start_addr),
        .word_count (word_count),
        .seed_eff   (seed_eff),
        .data_step  (data_step),
        .addr_step  (addr_step),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/io_pattern_writer_chk.sv
// Checker for the pattern writer's port protocol, bound to the top module.
module io_pattern_writer_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CW-1:0] word_count,
    input logic          in_ready,
    input logic          in_valid,
    input logic          wr_valid,
    input logic [DW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_ready,
    input logic          busy,
    input logic          done
);
    // R9: address held through a stall
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));
    // R9: data held through a stall
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_data));
    // R4: done lasts a single cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: no request while idle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !in_ready));
    // R8: zero-length command completes at once without a write
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && word_count == '0) |=> (done && !wr_valid));
    // R7: a stream word is taken only together with an accepted write
    a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |-> (wr_valid && wr_ready));
endmodule

bind io_pattern_writer io_pattern_writer_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_count (word_count),
    .in_ready   (in_ready),
    .in_valid   (in_valid),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_io_pattern_writer.sv
module sim_io_pattern_writer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    // Command vectors: R3 basic, R2 insert, R5 wrap, R6 len0, R1 disabled, R7 copy, R5 descending
    localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFF8,
        32'h0000_4000, 32'h0000_5000, 32'h0000_0300, 32'h0000_8000};
    localparam logic [15:0] V_CNT  [NV] = '{16'd4, 16'd3, 16'd4, 16'd2, 16'd2, 16'd5, 16'd3};
    localparam logic [31:0] V_SEED [NV] = '{32'h0000_0010, 32'hFFFF_0000, 32'hFFFF_FFFE,
        32'h0000_1234, 32'h0000_0000, 32'h0, 32'h0000_0100};
    localparam logic [31:0] V_CTL  [NV] = '{32'h0, 32'h8000_0104, 32'h0, 32'h8000_0003,
        32'h0000_0200, 32'h0, 32'h0};
    localparam logic [31:0] V_DST  [NV] = '{32'h1, 32'h100, 32'h1, 32'h2, 32'h3, 32'h7, 32'h10};
    localparam logic [31:0] V_AST  [NV] = '{32'h4, 32'h8, 32'h4, 32'h4, 32'h4, 32'h10, 32'hFFFF_FFFC};
    localparam logic [31:0] V_BASE [NV] = '{32'h0, 32'h0000_00AB, 32'h0, 32'hFFFF_FFFF,
        32'h0000_DEAD, 32'h0, 32'h0};
    localparam logic        V_COPY [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        copy_mode = 1'b0;
    logic [31:0] start_addr = '0, seed_data = '0, ins_ctl = '0;
    logic [31:0] data_step = '0, addr_step = '0, mem_base = '0, in_data = '0;
    logic [15:0] word_count = '0;
    logic        in_valid = 1'b0, wr_ready = 1'b0;
    logic        in_ready, wr_valid, busy, done;
    logic [31:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_pattern_writer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .copy_mode(copy_mode),
        .start_addr(start_addr), .word_count(word_count), .seed_data(seed_data),
        .ins_ctl(ins_ctl), .data_step(data_step), .addr_step(addr_step),
        .mem_base(mem_base), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected seed from the requirement text: rotate left, replace low len bits.
    function automatic logic [31:0] exp_seed(input logic [31:0] s, input logic [31:0] c,
                                             input logic [31:0] b);
        logic [31:0] r = b;
        logic [31:0] m = 32'h0;
        if (!c[31] || c[9:5] == 5'd0) return s;
        for (int i = 0; i < int'(c[4:0]); i++) r = {r[30:0], r[31]};
        for (int i = 0; i < int'(c[9:5]); i++) m[i] = 1'b1;
        return (s & ~m) | (r & m);
    endfunction

    function automatic logic [31:0] stream_word(input int k);
        return 32'hC0DE_0000 + 32'(k * 3);
    endfunction

    // Runs one command; poke issues a second start mid-run (R10).
    task automatic run_cmd(input int v, input bit poke);
        logic [31:0] ea, ed;
        int wrote = 0;
        int dones = 0;
        @(negedge clk);
        start_addr = V_ADDR[v]; word_count = V_CNT[v]; seed_data = V_SEED[v];
        ins_ctl = V_CTL[v]; data_step = V_DST[v]; addr_step = V_AST[v];
        mem_base = V_BASE[v]; copy_mode = V_COPY[v]; start = 1'b1;
        ea = V_ADDR[v];
        ed = exp_seed(V_SEED[v], V_CTL[v], V_BASE[v]);
        @(negedge clk);
        start = 1'b0;
        in_valid = copy_mode;
        for (int cyc = 0; cyc < 200 && dones == 0; cyc++) begin
            if (cyc > 0) @(negedge clk);
            rdy_cnt++;
            wr_ready = (rdy_cnt % 3) != 2;
            in_data = stream_word(wrote);
            if (poke && cyc == 1) begin
                start = 1'b1; start_addr = 32'h0BAD_0000; word_count = 16'd9;
            end else begin
                start = 1'b0;
            end
            #1;
            if (done) dones++;
            if (wr_valid && wr_ready) begin
                chk($sformatf("R3/R5 addr v%0d w%0d", v, wrote), wr_addr, ea);
                if (V_COPY[v]) begin
                    chk($sformatf("R7 copy data w%0d", wrote), wr_data, stream_word(wrote));
                    chk("R7 in_ready", 32'(in_ready), 32'h1);
                end else begin
                    chk($sformatf("R1/R2/R3/R6 data v%0d w%0d", v, wrote), wr_data, ed);
                    ed = ed + V_DST[v];
                end
                ea = ea + V_AST[v];
                wrote++;
            end
        end
        start = 1'b0;
        in_valid = 1'b0;
        chk($sformatf("R4 write count v%0d", v), 32'(wrote), 32'(V_CNT[v]));
        chk("R4 busy low at done", 32'(busy), 32'h0);
        @(negedge clk); #1;
        chk("R4 done single cycle", 32'(done), 32'h0);
        chk("R10 no second command", 32'(wr_valid || busy), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset wr_valid", 32'(wr_valid), 32'h0);
        chk("R11 reset busy", 32'(busy), 32'h0);
        chk("R11 reset done", 32'(done), 32'h0);
        chk("R11 reset in_ready", 32'(in_ready), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 idle after reset", 32'(wr_valid || busy || done), 32'h0);

        for (int v = 0; v < NV; v++) run_cmd(v, 1'b0);

        // R10: start during a run is ignored
        run_cmd(0, 1'b1);

        // R8: zero count
        @(negedge clk);
        word_count = 16'd0; start_addr = 32'h7777_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R8 done after zero count", 32'(done), 32'h1);
        chk("R8 no write", 32'(wr_valid), 32'h0);
        chk("R8 not busy", 32'(busy), 32'h0);
        @(negedge clk); #1;
        chk("R8 done drops", 32'(done), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule